// File: doc/BRIEF.md
# Packet Header Parser for a Serial Bus Master

This block sits on the stream of 32-bit transmit words that feed a packet-driven serial bus master. Every packet opens with three header words. The parser reads them, checks that the first one is tagged for the serial bus protocol, and decodes the third into a transfer descriptor. The descriptor carries the target address (7-bit or 10-bit), the direction, the byte count, the action at the end of the transfer, continue-on-NACK, high-speed and start-byte. It offers the descriptor to a bus engine through a valid/ready handshake.

For a write, payload words follow the header. Each holds up to four bytes. The parser splits them into a byte stream, least significant byte first, and marks the final byte. Lanes of the last word that lie beyond the byte count are thrown away. For a read, no payload words follow the header. In both cases the parser then waits for the engine's done pulse before it accepts the next header.

A first word without the protocol tag raises a one-cycle error pulse. The parser still reads the two remaining header words. It then silently consumes the write payload that the count announces, or none for a read, so that the stream stays aligned on packet boundaries.

Top module: `pkt_hdr_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `desc_valid`, `byte_valid` and `hdr_err` are 0.
- R2: `desc_len` equals the value of header word 1, bits LEN_W-1:0, plus one. With the default LEN_W of 12, a field of 4095 gives 4096.
- R3: When word 2 bit 18 is clear, `desc_ten_bit` is 0 and `desc_addr` holds word 2 bits 7:1 zero-extended. When bit 18 is set, `desc_ten_bit` is 1 and `desc_addr` holds word 2 bits 9:0.
- R4: `desc_end` is 2 (continue without start or stop) when word 2 bit 15 is set. Otherwise it is 1 (repeated start) when bit 16 is set, and otherwise 0 (stop). The value 3 never appears.
- R5: `desc_read` copies word 2 bit 19, `desc_nack_cont` copies bit 21, `desc_hs` copies bit 22 and `desc_start_byte` copies bit 20.
- R6: For a write, exactly `desc_len` bytes are issued. Within a word, bits 7:0 go first and bits 31:24 last. `byte_last` marks only the final byte, and lanes of the last word beyond the count are never issued. A payload word is taken only after every byte of the previous word has been accepted.
- R7: For a read, once the descriptor handshake is done, no payload word is taken (`in_ready` 0) and no byte is offered.
- R8: After the final byte of a write, or after the descriptor handshake of a read, the parser holds `in_ready` at 0 until `eng_done` is high. In the following cycle it is ready for a new header. An `eng_done` pulse in any other state has no effect.
- R9: If word 0 bit 4 is 0, `hdr_err` is high for exactly the one cycle after that word is taken, and no descriptor is offered for the packet. The parser then consumes ceil(count/4) payload words for a write, or none for a read, and parses the next word as a new header.
- R10: While `desc_valid` is high and `desc_ready` is low, `desc_valid` and all descriptor outputs hold. While `byte_valid` is high and `byte_ready` is low, `byte_valid`, `byte_data` and `byte_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 32 | Transmit stream word |
| in_valid | input | 1 | Transmit word present |
| in_ready | output | 1 | Parser takes the word this cycle |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Engine takes the descriptor |
| desc_addr | output | 10 | Target address |
| desc_ten_bit | output | 1 | 10-bit addressing |
| desc_read | output | 1 | Read transfer |
| desc_nack_cont | output | 1 | Continue on NACK |
| desc_hs | output | 1 | High-speed transfer |
| desc_start_byte | output | 1 | Send start byte first |
| desc_end | output | 2 | End action: 0 stop, 1 repeated start, 2 continue |
| desc_len | output | LEN_W+1 | Byte count |
| byte_valid | output | 1 | Write byte offered |
| byte_ready | input | 1 | Engine takes the byte |
| byte_data | output | 8 | Write byte |
| byte_last | output | 1 | Final byte of the transfer |
| eng_done | input | 1 | Engine finished the transfer |
| hdr_err | output | 1 | Bad protocol tag seen on word 0 |

## Verification
The hardest state to reach is the discard path after a bad header. It has to consume exactly the announced number of payload words, and from the ports it looks the same as ordinary readiness. The bench sends bad headers with counts of 1, 4, 5 and 9 and with both directions. It follows each one with a good packet whose header must decode cleanly. One word too many swallows the next header, which starves the descriptor check. One word too few makes a leftover payload word, built with bit 4 clear, raise an unexpected header error. The sweep also covers every end-flag pair, both address widths, counts from 1 to 9, and stalls with stray `eng_done` pulses on the descriptor handshake.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;

  localparam int WORD_BYTES = 4;
  localparam int PROTO_BIT  = 4;

  typedef enum logic [1:0] {
    END_STOP   = 2'd0,
    END_RSTART = 2'd1,
    END_CONT   = 2'd2
  } end_act_e;

  typedef struct packed {
    logic [9:0] addr;
    logic       ten_bit;
    logic       rd;
    logic       nack_cont;
    logic       hs;
    logic       start_byte;
    end_act_e   end_act;
  } xfer_desc_t;

  typedef enum logic [2:0] {
    S_HDR0, S_HDR1, S_HDR2, S_DESC, S_LOAD, S_EMIT, S_WAIT, S_DRAIN
  } pstate_e;

endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
  import pkt_hdr_pkg::*;
(
  input  logic [4:0]  hi_flags,   // word 2 bits 22:18
  input  logic [1:0]  end_flags,  // word 2 bits 16:15
  input  logic [9:0]  addr_field, // word 2 bits 9:0
  output xfer_desc_t  desc
);
  logic ten;
  assign ten = hi_flags[0];

  always_comb begin
    desc.ten_bit    = ten;
    desc.addr       = ten ? addr_field : {3'b000, addr_field[7:1]};
    desc.rd         = hi_flags[1];
    desc.start_byte = hi_flags[2];
    desc.nack_cont  = hi_flags[3];
    desc.hs         = hi_flags[4];
    if (end_flags[0])      desc.end_act = END_CONT;
    else if (end_flags[1]) desc.end_act = END_RSTART;
    else                   desc.end_act = END_STOP;
  end
endmodule

// File: rtl/byte_lane_pick.sv
module byte_lane_pick #(
  parameter int LANES = 4,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*8-1:0] word,
  input  logic [SEL_W-1:0]   sel,
  output logic [7:0]         lane_byte
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[g*8 +: 8];
  end

  assign lane_byte = lanes[sel];
endmodule

// File: rtl/pkt_hdr_parser.sv
module pkt_hdr_parser
  import pkt_hdr_pkg::*;
#(
  parameter int LEN_W = 12,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      in_word,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [9:0]       desc_addr,
  output logic             desc_ten_bit,
  output logic             desc_read,
  output logic             desc_nack_cont,
  output logic             desc_hs,
  output logic             desc_start_byte,
  output logic [1:0]       desc_end,
  output logic [CNT_W-1:0] desc_len,
  output logic             byte_valid,
  input  logic             byte_ready,
  output logic [7:0]       byte_data,
  output logic             byte_last,
  input  logic             eng_done,
  output logic             hdr_err
);
  localparam int SEL_W = $clog2(WORD_BYTES);
  localparam logic [SEL_W-1:0] LAST_LANE = SEL_W'(WORD_BYTES - 1);
  localparam logic [CNT_W-1:0] WB = CNT_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pstate_e            state_q, state_d;
  xfer_desc_t         desc_q, dec;
  logic [CNT_W-1:0]   len_q, rem_q, rem_d;
  logic [31:0]        word_q;
  logic [SEL_W-1:0]   lane_q, lane_d;
  logic               err_q, err_d, hdr_err_q, hdr_err_d;
  logic               acc, byte_acc;
  logic               en_err, en_len, en_rem, en_desc, en_word, en_lane;

  hdr_decode u_dec (
    .hi_flags   (in_word[22:18]),
    .end_flags  (in_word[16:15]),
    .addr_field (in_word[9:0]),
    .desc       (dec)
  );

  byte_lane_pick #(.LANES(WORD_BYTES)) u_pick (
    .word      (word_q),
    .sel       (lane_q),
    .lane_byte (byte_data)
  );

  assign in_ready = (state_q == S_HDR0) || (state_q == S_HDR1) ||
                    (state_q == S_HDR2) || (state_q == S_LOAD) ||
                    (state_q == S_DRAIN);
  assign acc        = in_valid && in_ready;
  assign byte_valid = (state_q == S_EMIT);
  assign byte_acc   = byte_valid && byte_ready;
  assign byte_last  = (rem_q == ONE);
  assign desc_valid = (state_q == S_DESC);

  // next state and register enables
  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    rem_d     = rem_q;
    lane_d    = lane_q;
    hdr_err_d = 1'b0;
    en_err    = 1'b0;
    en_len    = 1'b0;
    en_rem    = 1'b0;
    en_desc   = 1'b0;
    en_word   = 1'b0;
    en_lane   = 1'b0;
    unique case (state_q)
      S_HDR0: if (acc) begin
        en_err    = 1'b1;
        err_d     = !in_word[PROTO_BIT];
        hdr_err_d = !in_word[PROTO_BIT];
        state_d   = S_HDR1;
      end
      S_HDR1: if (acc) begin
        en_len  = 1'b1;
        state_d = S_HDR2;
      end
      S_HDR2: if (acc) begin
        en_desc = 1'b1;
        en_rem  = 1'b1;
        rem_d   = len_q;
        if (!err_q)      state_d = S_DESC;
        else if (dec.rd) state_d = S_HDR0;
        else             state_d = S_DRAIN;
      end
      S_DESC: if (desc_ready) state_d = desc_q.rd ? S_WAIT : S_LOAD;
      S_LOAD: if (acc) begin
        en_word = 1'b1;
        en_lane = 1'b1;
        lane_d  = '0;
        state_d = S_EMIT;
      end
      S_EMIT: if (byte_acc) begin
        en_rem  = 1'b1;
        rem_d   = rem_q - ONE;
        en_lane = 1'b1;
        lane_d  = lane_q + SEL_W'(1);
        if (rem_q == ONE)            state_d = S_WAIT;
        else if (lane_q == LAST_LANE) state_d = S_LOAD;
      end
      S_WAIT: if (eng_done) state_d = S_HDR0;
      S_DRAIN: if (acc) begin
        en_rem = 1'b1;
        if (rem_q <= WB) begin
          rem_d   = '0;
          state_d = S_HDR0;
        end else begin
          rem_d = rem_q - WB;
        end
      end
      default: state_d = S_HDR0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_HDR0;
      err_q     <= 1'b0;
      hdr_err_q <= 1'b0;
      len_q     <= '0;
      rem_q     <= '0;
      desc_q    <= '0;
      word_q    <= '0;
      lane_q    <= '0;
    end else begin
      state_q   <= state_d;
      hdr_err_q <= hdr_err_d;
      if (en_err)  err_q  <= err_d;
      if (en_len)  len_q  <= CNT_W'(in_word[LEN_W-1:0]) + ONE;
      if (en_rem)  rem_q  <= rem_d;
      if (en_desc) desc_q <= dec;
      if (en_word) word_q <= in_word;
      if (en_lane) lane_q <= lane_d;
    end
  end

  assign hdr_err         = hdr_err_q;
  assign desc_addr       = desc_q.addr;
  assign desc_ten_bit    = desc_q.ten_bit;
  assign desc_read       = desc_q.rd;
  assign desc_nack_cont  = desc_q.nack_cont;
  assign desc_hs         = desc_q.hs;
  assign desc_start_byte = desc_q.start_byte;
  assign desc_end        = desc_q.end_act;
  assign desc_len        = len_q;
endmodule

// File: rtl/pkt_hdr_parser_chk.sv
module pkt_hdr_parser_chk #(
  parameter int LEN_W = 12,
  localparam int CNT_W = LEN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic [9:0]       desc_addr,
  input logic [1:0]       desc_end,
  input logic [CNT_W-1:0] desc_len,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic [7:0]       byte_data,
  input logic             byte_last,
  input logic             hdr_err
);
  a_r10_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) &&
    $stable(desc_end) && $stable(desc_len));

  a_r10_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data) &&
    $stable(byte_last));

  a_r6_word_after_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && in_ready));

  a_r7_no_input_on_desc: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !in_ready && !byte_valid);

  a_r4_end_legal: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_end != 2'd3);

  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_len != '0);

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> !hdr_err && !desc_valid);

  a_r8_last_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_ready && byte_last |=> !in_ready && !byte_valid);
endmodule

bind pkt_hdr_parser pkt_hdr_parser_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .desc_addr  (desc_addr),
  .desc_end   (desc_end),
  .desc_len   (desc_len),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_data  (byte_data),
  .byte_last  (byte_last),
  .hdr_err    (hdr_err)
);

// File: tb/pkt_hdr_parser_test.sv
module pkt_hdr_parser_test;
  localparam int LEN_W = 12;
  localparam int CNT_W = LEN_W + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      in_word = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             desc_valid;
  logic             desc_ready = 1'b0;
  logic [9:0]       desc_addr;
  logic             desc_ten_bit, desc_read, desc_nack_cont, desc_hs, desc_start_byte;
  logic [1:0]       desc_end;
  logic [CNT_W-1:0] desc_len;
  logic             byte_valid;
  logic             byte_ready = 1'b0;
  logic [7:0]       byte_data;
  logic             byte_last;
  logic             eng_done = 1'b0;
  logic             hdr_err;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pkt_hdr_parser #(.LEN_W(LEN_W)) uut (.*);

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int k, input int seed);
    return 8'((k * 37 + seed * 11 + 5) & 255);
  endfunction

  // caller is at a falling edge
  task automatic send_word(input logic [31:0] w);
    in_word  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_pkt(input bit bad, input int len, input bit rd, input bit ten,
                         input logic [9:0] addr, input bit rs, input bit ct,
                         input bit nack, input bit hs, input int seed, input int stall);
    logic [31:0] w2, pw;
    int nwords;
    nwords = (len + 3) / 4;
    send_word(bad ? 32'h0001_1020 : 32'h0001_1010);
    expect_eq("R9 error pulse after word 0", 32'(hdr_err), 32'(bad));
    send_word(32'(len - 1));
    w2 = 32'h0002_0000 | (32'(hs) << 22) | (32'(nack) << 21) | (32'(seed & 1) << 20) |
         (32'(rd) << 19) | (32'(rs) << 16) | (32'(ct) << 15) |
         (ten ? (32'h0004_0000 | 32'(addr)) : (32'(addr[6:0]) << 1));
    send_word(w2);
    if (bad) begin
      if (!rd) for (int w = 0; w < nwords; w++) send_word(32'h0303_0303);
      expect_eq("R9 no descriptor after bad header", 32'(desc_valid), 32'd0);
      expect_eq("R9 ready for next header", 32'(in_ready), 32'd1);
      return;
    end
    while (!desc_valid) @(negedge clk);
    for (int s = 0; s < stall; s++) begin
      eng_done = (s == 0);
      @(negedge clk);
      eng_done = 1'b0;
    end
    expect_eq("R8 stray done ignored, R10 descriptor held", 32'(desc_valid), 32'd1);
    expect_eq("R2 length", 32'(desc_len), 32'(len));
    expect_eq("R3 address", 32'(desc_addr), ten ? 32'(addr) : 32'(addr[6:0]));
    expect_eq("R3 ten-bit flag", 32'(desc_ten_bit), 32'(ten));
    expect_eq("R4 end action", 32'(desc_end), ct ? 32'd2 : (rs ? 32'd1 : 32'd0));
    expect_eq("R5 read flag", 32'(desc_read), 32'(rd));
    expect_eq("R5 nack flag", 32'(desc_nack_cont), 32'(nack));
    expect_eq("R5 hs flag", 32'(desc_hs), 32'(hs));
    expect_eq("R5 start-byte flag", 32'(desc_start_byte), 32'(seed & 1));
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    if (rd) begin
      for (int c = 0; c < 3; c++) begin
        expect_eq("R7 no payload taken on read", 32'(in_ready), 32'd0);
        expect_eq("R7 no byte on read", 32'(byte_valid), 32'd0);
        @(negedge clk);
      end
    end else begin
      for (int w = 0; w < nwords; w++) begin
        expect_eq("R6 no byte before word", 32'(byte_valid), 32'd0);
        pw = '0;
        for (int b = 0; b < 4; b++)
          pw[b*8 +: 8] = (w * 4 + b < len) ? pbyte(w * 4 + b, seed) : 8'hE7;
        send_word(pw);
        for (int b = 0; b < 4 && w * 4 + b < len; b++) begin
          while (!byte_valid) @(negedge clk);
          expect_eq("R6 byte value", 32'(byte_data), 32'(pbyte(w * 4 + b, seed)));
          expect_eq("R6 last marker", 32'(byte_last), 32'(w * 4 + b == len - 1));
          byte_ready = 1'b1;
          @(negedge clk);
          byte_ready = 1'b0;
        end
      end
      expect_eq("R6 no extra byte", 32'(byte_valid), 32'd0);
    end
    expect_eq("R8 waiting for done", 32'(in_ready), 32'd0);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    expect_eq("R8 header state after done", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R1 reset in_ready", 32'(in_ready), 32'd1);
    expect_eq("R1 reset desc_valid", 32'(desc_valid), 32'd0);
    expect_eq("R1 reset byte_valid", 32'(byte_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R1 hdr_err idle", 32'(hdr_err), 32'd0);

    // writes: every count 1..9 with every end-flag pair
    for (int l = 1; l <= 9; l++)
      for (int e = 0; e < 4; e++)
        run_pkt(0, l, 0, l[0], 10'(l * 71 + e), e[1], e[0], e[0] ^ l[1], e[1], l + e, e);
    // reads: both address widths, all end flags, short and maximum counts
    for (int t = 0; t < 2; t++)
      for (int e = 0; e < 4; e++)
        run_pkt(0, (e == 3) ? 4096 : e * 5 + 1, 1, t[0], 10'(e * 203 + 77 + t), e[1], e[0],
                e[1], t[0], e, 2);
    // bad headers, each followed by a good packet
    run_pkt(1, 1, 0, 0, 10'h12, 0, 0, 0, 0, 0, 0);
    run_pkt(0, 3, 0, 0, 10'h55, 1, 0, 0, 0, 7, 1);
    run_pkt(1, 4, 0, 1, 10'h2A1, 0, 1, 0, 0, 0, 0);
    run_pkt(0, 5, 0, 1, 10'h3FF, 0, 0, 1, 1, 9, 0);
    run_pkt(1, 5, 0, 0, 10'h40, 0, 0, 0, 0, 0, 0);
    run_pkt(0, 2, 1, 0, 10'h7F, 0, 0, 0, 0, 3, 0);
    run_pkt(1, 9, 0, 0, 10'h11, 1, 0, 0, 0, 0, 0);
    run_pkt(1, 8, 1, 0, 10'h11, 1, 0, 0, 0, 0, 0);
    run_pkt(0, 9, 0, 0, 10'h01, 0, 0, 0, 0, 4, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule